// File: doc/BRIEF.md
# Trace Line Lookup Array

This block is a direct-mapped store of dynamic instruction traces. A fetch unit reads it with one access per cycle. Each line holds up to sixteen instruction words. Those words can span up to three consecutive basic blocks, and the blocks need not be contiguous in memory. A hit delivers the whole trace in one access, already in execution order, so the fetch unit needs no second cache port and no alignment stage. A fill unit writes complete lines through a separate write port.

Each lookup presents a fetch address and up to three branch predictions. A hit needs two things:

- the line is valid and its tag equals the address tag;
- the direction flags stored for the branches inside the line agree with the matching predictions.

On a full hit the block returns:

- the stored instruction count and the instruction words;
- the next fetch address, chosen by the prediction of the line's final branch.

When a disagreement is found and the requester allows partial matches, the block returns a shorter prefix instead. The prefix ends with the first branch whose stored flag disagrees with its prediction. All addresses are instruction-word addresses. Instruction words are opaque 32-bit values.

Top module: `trace_line_lookup`

## Requirements
- R1: After reset every line is invalid. While reset is applied and until a lookup is presented, `rsp_vld`, `rsp_hit` and `rsp_count` are 0. Any lookup after reset misses.
- R2: A lookup sampled at a rising clock edge with `req_vld`=1 produces its results right after that same edge. `rsp_vld` equals `req_vld` from the previous edge.
- R3: The line index is address bits [5:0] and the tag is bits [31:6]. A lookup whose tag differs from the stored tag of a valid line at the same index misses.
- R4: Full hit. The tag matches, and `req_pred[i]` equals stored flag i for every i below the line's branch count. Then `rsp_hit`=1, `rsp_partial`=0 and `rsp_count` equals the stored length. Bit i of the predictions and flags belongs to the i-th branch in trace order, and 1 means taken.
- R5: Prediction bits at or above the line's branch count have no effect on the result. A line with branch count 0 hits on a tag match whatever the predictions are.
- R6: On a full hit the next fetch address is chosen as follows. If the line's last-slot-is-branch flag is set, the prediction of branch (count-1) picks the taken target when 1 and the fall-through address when 0. If the flag is clear, the fall-through address is used.
- R7: A tag match with a disagreeing branch and `req_partial_ok`=0 is a miss. Every miss gives `rsp_hit`=0, `rsp_count`=0, `rsp_next_addr`=0 and all-zero words.
- R8: With `req_partial_ok`=1, a tag match whose first disagreeing branch is branch k gives `rsp_hit`=1, `rsp_partial`=1 and `rsp_next_addr`=0. `rsp_count` is one more than the slot number of the (k+1)-th set bit of the stored branch mask.
- R9: Word slots at or above `rsp_count` read as zero.
- R10: A fill writes the whole line and marks it valid from the next cycle. A lookup of the same index in the same cycle returns the line's previous contents.
- R11: Instruction slot s occupies bits [32s+31:32s] of both `fill_words` and `rsp_words`. Bit s of the branch mask marks slot s as a branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | 1 | Lookup request this cycle |
| req_addr | input | 32 | Fetch word address |
| req_pred | input | 3 | Predicted directions for branches 0..2, 1 = taken |
| req_partial_ok | input | 1 | Accept a prefix up to the first disagreeing branch |
| fill_en | input | 1 | Write a line this cycle |
| fill_addr | input | 32 | Start word address of the line being written |
| fill_len | input | 5 | Number of valid instructions, 1..16 |
| fill_br_cnt | input | 2 | Number of branches in the line, 0..3 |
| fill_br_mask | input | 16 | Slots holding branches |
| fill_br_dir | input | 3 | Recorded directions of branches 0..2 |
| fill_last_br | input | 1 | Last valid slot is a branch |
| fill_fall_addr | input | 32 | Successor if the final branch is not taken or absent |
| fill_taken_addr | input | 32 | Successor if the final branch is taken |
| fill_words | input | 512 | Sixteen instruction words |
| rsp_vld | output | 1 | Result of last cycle's lookup is present |
| rsp_hit | output | 1 | Full or partial hit |
| rsp_partial | output | 1 | Hit is a truncated prefix |
| rsp_count | output | 5 | Number of valid instructions returned |
| rsp_next_addr | output | 32 | Next fetch address (0 on miss or partial hit) |
| rsp_words | output | 512 | Instruction words, zero beyond the count |

## Verification
Every lookup result is due one clock after its request. The bench drives each request at a falling edge and compares all response ports at the next falling edge, so exactly one rising edge lies between stimulus and check. A fill takes effect at the same rising edge that samples a lookup, yet that lookup must see the old line. The bench model therefore computes each expectation before it applies that cycle's fill. After reset is released, the internal synchronizer holds the block for two more edges, and the bench waits out that interval before it issues any request.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int TC_AW    = 32;
  localparam int TC_IW    = 32;
  localparam int TC_LINES = 64;
  localparam int TC_SLOTS = 16;
  localparam int TC_BR    = 3;

  typedef enum logic [1:0] {
    TC_MISS = 2'd0,
    TC_FULL = 2'd1,
    TC_PART = 2'd2
  } tc_outcome_e;
endpackage

// File: rtl/tc_line_store.sv
module tc_line_store #(
  parameter int LINES = 64,
  parameter int TAG_W = 26,
  parameter int SLOTS = 16,
  parameter int BR    = 3,
  parameter int AW    = 32,
  parameter int IW    = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int LEN_W = $clog2(SLOTS + 1),
  localparam int CNT_W = $clog2(BR + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [LEN_W-1:0]    wr_len,
  input  logic [CNT_W-1:0]    wr_cnt,
  input  logic [SLOTS-1:0]    wr_mask,
  input  logic [BR-1:0]       wr_dir,
  input  logic                wr_last,
  input  logic [AW-1:0]       wr_fall,
  input  logic [AW-1:0]       wr_taken,
  input  logic [SLOTS*IW-1:0] wr_words,
  output logic                rd_valid,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [LEN_W-1:0]    rd_len,
  output logic [CNT_W-1:0]    rd_cnt,
  output logic [SLOTS-1:0]    rd_mask,
  output logic [BR-1:0]       rd_dir,
  output logic                rd_last,
  output logic [AW-1:0]       rd_fall,
  output logic [AW-1:0]       rd_taken,
  output logic [SLOTS*IW-1:0] rd_words
);

  logic [TAG_W-1:0]    tag_mem   [LINES];
  logic [LEN_W-1:0]    len_mem   [LINES];
  logic [CNT_W-1:0]    cnt_mem   [LINES];
  logic [SLOTS-1:0]    mask_mem  [LINES];
  logic [BR-1:0]       dir_mem   [LINES];
  logic                last_mem  [LINES];
  logic [AW-1:0]       fall_mem  [LINES];
  logic [AW-1:0]       taken_mem [LINES];
  logic [SLOTS*IW-1:0] word_mem  [LINES];

  logic [LINES-1:0] valid_q, valid_d;
  logic             rd_valid_q, rd_valid_d;

  // next state for per-line valid bits and the read-side valid flag
  always_comb begin
    valid_d = valid_q;
    if (wr_en) valid_d[wr_idx] = 1'b1;
    rd_valid_d = rd_en ? valid_q[rd_idx] : rd_valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      valid_q    <= valid_d;
      rd_valid_q <= rd_valid_d;
    end
  end

  // line payload: write-enabled, no reset
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]   <= wr_tag;
      len_mem[wr_idx]   <= wr_len;
      cnt_mem[wr_idx]   <= wr_cnt;
      mask_mem[wr_idx]  <= wr_mask;
      dir_mem[wr_idx]   <= wr_dir;
      last_mem[wr_idx]  <= wr_last;
      fall_mem[wr_idx]  <= wr_fall;
      taken_mem[wr_idx] <= wr_taken;
      word_mem[wr_idx]  <= wr_words;
    end
  end

  // registered read: samples contents before a same-edge write lands
  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag   <= tag_mem[rd_idx];
      rd_len   <= len_mem[rd_idx];
      rd_cnt   <= cnt_mem[rd_idx];
      rd_mask  <= mask_mem[rd_idx];
      rd_dir   <= dir_mem[rd_idx];
      rd_last  <= last_mem[rd_idx];
      rd_fall  <= fall_mem[rd_idx];
      rd_taken <= taken_mem[rd_idx];
      rd_words <= word_mem[rd_idx];
    end
  end

  assign rd_valid = rd_valid_q;

  // R10: a fill leaves its line valid
  p_fill_sets_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)]);

  // R10: a read that collides with a fill reports the line's prior validity
  p_collide_old_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && rd_idx == wr_idx && !valid_q[wr_idx]) |=> !rd_valid);

endmodule

// File: rtl/tc_match.sv
module tc_match
  import tc_pkg::*;
#(
  parameter int TAG_W = 26,
  parameter int SLOTS = 16,
  parameter int BR    = 3,
  parameter int AW    = 32,
  parameter int IW    = 32,
  localparam int LEN_W = $clog2(SLOTS + 1),
  localparam int CNT_W = $clog2(BR + 1),
  localparam int POS_W = $clog2(SLOTS)
) (
  input  logic                req_vld,
  input  logic [TAG_W-1:0]    req_tag,
  input  logic [BR-1:0]       req_pred,
  input  logic                req_part_ok,
  input  logic                line_valid,
  input  logic [TAG_W-1:0]    line_tag,
  input  logic [LEN_W-1:0]    line_len,
  input  logic [CNT_W-1:0]    line_cnt,
  input  logic [SLOTS-1:0]    line_mask,
  input  logic [BR-1:0]       line_dir,
  input  logic                line_last,
  input  logic [AW-1:0]       line_fall,
  input  logic [AW-1:0]       line_taken,
  input  logic [SLOTS*IW-1:0] line_words,
  output logic                hit,
  output logic                partial,
  output logic [LEN_W-1:0]    count,
  output logic [AW-1:0]       next_addr,
  output logic [SLOTS*IW-1:0] words
);

  logic              tag_ok;
  logic [BR-1:0]     disagree;
  logic [CNT_W-1:0]  first_k;
  logic [LEN_W-1:0]  seen;
  logic [POS_W-1:0]  cut_slot;
  logic              cut_found;
  tc_outcome_e       outcome;

  assign tag_ok = req_vld && line_valid && (line_tag == req_tag);

  // compare only the branches the line actually holds
  always_comb begin
    for (int i = 0; i < BR; i++) begin
      disagree[i] = (i < int'(line_cnt)) && (line_dir[i] != req_pred[i]);
    end
    first_k = '0;
    for (int i = BR - 1; i >= 0; i--) begin
      if (disagree[i]) first_k = CNT_W'(i);
    end
  end

  // locate the slot of the first disagreeing branch in the mask
  always_comb begin
    seen      = '0;
    cut_slot  = '0;
    cut_found = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if (line_mask[s]) begin
        if (!cut_found && seen == LEN_W'(first_k)) begin
          cut_slot  = POS_W'(s);
          cut_found = 1'b1;
        end
        seen = seen + 1'b1;
      end
    end
  end

  always_comb begin
    if (!tag_ok)            outcome = TC_MISS;
    else if (~|disagree)    outcome = TC_FULL;
    else if (req_part_ok)   outcome = TC_PART;
    else                    outcome = TC_MISS;
  end

  always_comb begin
    hit       = 1'b0;
    partial   = 1'b0;
    count     = '0;
    next_addr = '0;
    case (outcome)
      TC_FULL: begin
        hit   = 1'b1;
        count = line_len;
        if (line_last && line_cnt != '0)
          next_addr = req_pred[line_cnt - 1'b1] ? line_taken : line_fall;
        else
          next_addr = line_fall;
      end
      TC_PART: begin
        hit     = 1'b1;
        partial = 1'b1;
        count   = LEN_W'(cut_slot) + LEN_W'(1);
      end
      default: ;
    endcase
  end

  // slot gating: only the delivered prefix is driven
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign words[s*IW +: IW] = (LEN_W'(s) < count) ? line_words[s*IW +: IW] : '0;
  end

endmodule

// File: rtl/trace_line_lookup.sv
module trace_line_lookup #(
  parameter int AW    = tc_pkg::TC_AW,
  parameter int IW    = tc_pkg::TC_IW,
  parameter int LINES = tc_pkg::TC_LINES,
  parameter int SLOTS = tc_pkg::TC_SLOTS,
  parameter int BR    = tc_pkg::TC_BR,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = AW - IDX_W,
  localparam int LEN_W = $clog2(SLOTS + 1),
  localparam int CNT_W = $clog2(BR + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_vld,
  input  logic [AW-1:0]       req_addr,
  input  logic [BR-1:0]       req_pred,
  input  logic                req_partial_ok,
  input  logic                fill_en,
  input  logic [AW-1:0]       fill_addr,
  input  logic [LEN_W-1:0]    fill_len,
  input  logic [CNT_W-1:0]    fill_br_cnt,
  input  logic [SLOTS-1:0]    fill_br_mask,
  input  logic [BR-1:0]       fill_br_dir,
  input  logic                fill_last_br,
  input  logic [AW-1:0]       fill_fall_addr,
  input  logic [AW-1:0]       fill_taken_addr,
  input  logic [SLOTS*IW-1:0] fill_words,
  output logic                rsp_vld,
  output logic                rsp_hit,
  output logic                rsp_partial,
  output logic [LEN_W-1:0]    rsp_count,
  output logic [AW-1:0]       rsp_next_addr,
  output logic [SLOTS*IW-1:0] rsp_words
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // request stage, aligned with the registered array read
  logic             q_vld_q, q_vld_d;
  logic [TAG_W-1:0] q_tag_q, q_tag_d;
  logic [BR-1:0]    q_pred_q, q_pred_d;
  logic             q_part_q, q_part_d;

  always_comb begin
    q_vld_d  = req_vld;
    q_tag_d  = req_vld ? req_addr[AW-1:IDX_W] : q_tag_q;
    q_pred_d = req_vld ? req_pred             : q_pred_q;
    q_part_d = req_vld ? req_partial_ok       : q_part_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) q_vld_q <= 1'b0;
    else            q_vld_q <= q_vld_d;
  end

  always_ff @(posedge clk) begin
    q_tag_q  <= q_tag_d;
    q_pred_q <= q_pred_d;
    q_part_q <= q_part_d;
  end

  logic                l_valid, l_last;
  logic [TAG_W-1:0]    l_tag;
  logic [LEN_W-1:0]    l_len;
  logic [CNT_W-1:0]    l_cnt;
  logic [SLOTS-1:0]    l_mask;
  logic [BR-1:0]       l_dir;
  logic [AW-1:0]       l_fall, l_taken;
  logic [SLOTS*IW-1:0] l_words;

  tc_line_store #(
    .LINES(LINES), .TAG_W(TAG_W), .SLOTS(SLOTS), .BR(BR), .AW(AW), .IW(IW)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rd_en    (req_vld),
    .rd_idx   (req_addr[IDX_W-1:0]),
    .wr_en    (fill_en),
    .wr_idx   (fill_addr[IDX_W-1:0]),
    .wr_tag   (fill_addr[AW-1:IDX_W]),
    .wr_len   (fill_len),
    .wr_cnt   (fill_br_cnt),
    .wr_mask  (fill_br_mask),
    .wr_dir   (fill_br_dir),
    .wr_last  (fill_last_br),
    .wr_fall  (fill_fall_addr),
    .wr_taken (fill_taken_addr),
    .wr_words (fill_words),
    .rd_valid (l_valid),
    .rd_tag   (l_tag),
    .rd_len   (l_len),
    .rd_cnt   (l_cnt),
    .rd_mask  (l_mask),
    .rd_dir   (l_dir),
    .rd_last  (l_last),
    .rd_fall  (l_fall),
    .rd_taken (l_taken),
    .rd_words (l_words)
  );

  tc_match #(
    .TAG_W(TAG_W), .SLOTS(SLOTS), .BR(BR), .AW(AW), .IW(IW)
  ) u_match (
    .req_vld     (q_vld_q),
    .req_tag     (q_tag_q),
    .req_pred    (q_pred_q),
    .req_part_ok (q_part_q),
    .line_valid  (l_valid),
    .line_tag    (l_tag),
    .line_len    (l_len),
    .line_cnt    (l_cnt),
    .line_mask   (l_mask),
    .line_dir    (l_dir),
    .line_last   (l_last),
    .line_fall   (l_fall),
    .line_taken  (l_taken),
    .line_words  (l_words),
    .hit         (rsp_hit),
    .partial     (rsp_partial),
    .count       (rsp_count),
    .next_addr   (rsp_next_addr),
    .words       (rsp_words)
  );

  assign rsp_vld = q_vld_q;

  // R2: a sampled request yields a response in the next cycle
  p_req_to_rsp_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_vld |=> rsp_vld);

  // R1, R2: no result without a request
  p_idle_no_hit_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rsp_vld |-> (!rsp_hit && rsp_count == '0));

  // R7: a miss carries no payload
  p_miss_empty_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rsp_hit |-> (rsp_count == '0 && rsp_next_addr == '0 && rsp_words == '0));

  // R8: a truncated hit is a hit with a non-empty prefix and no successor
  p_partial_shape_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_partial |-> (rsp_hit && rsp_count != '0 && rsp_next_addr == '0));

  // R4: count never exceeds the line capacity
  p_count_cap_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    rsp_count <= LEN_W'(SLOTS));

endmodule

// File: tb/tb_trace_line_lookup.sv
`timescale 1ns/1ps
module tb_trace_line_lookup;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_vld, req_partial_ok, fill_en, fill_last_br;
  logic [31:0]  req_addr, fill_addr, fill_fall_addr, fill_taken_addr;
  logic [2:0]   req_pred, fill_br_dir;
  logic [4:0]   fill_len;
  logic [1:0]   fill_br_cnt;
  logic [15:0]  fill_br_mask;
  logic [511:0] fill_words;
  logic         rsp_vld, rsp_hit, rsp_partial;
  logic [4:0]   rsp_count;
  logic [31:0]  rsp_next_addr;
  logic [511:0] rsp_words;

  always #2.5 clk = ~clk;

  trace_line_lookup dut (
    .clk(clk), .rst_n(rst_n),
    .req_vld(req_vld), .req_addr(req_addr), .req_pred(req_pred),
    .req_partial_ok(req_partial_ok),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_len(fill_len),
    .fill_br_cnt(fill_br_cnt), .fill_br_mask(fill_br_mask),
    .fill_br_dir(fill_br_dir), .fill_last_br(fill_last_br),
    .fill_fall_addr(fill_fall_addr), .fill_taken_addr(fill_taken_addr),
    .fill_words(fill_words),
    .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_partial(rsp_partial),
    .rsp_count(rsp_count), .rsp_next_addr(rsp_next_addr), .rsp_words(rsp_words)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  // bench model of the array
  bit           m_v    [64];
  logic [25:0]  m_tag  [64];
  logic [4:0]   m_len  [64];
  logic [1:0]   m_cnt  [64];
  logic [15:0]  m_mask [64];
  logic [2:0]   m_dir  [64];
  logic         m_last [64];
  logic [31:0]  m_fall [64];
  logic [31:0]  m_tkn  [64];
  logic [511:0] m_words[64];

  logic         e_vld, e_hit, e_part;
  logic [4:0]   e_cnt;
  logic [31:0]  e_next;
  logic [511:0] e_words;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic expect_for(input logic [31:0] a, input logic [2:0] p, input bit pe);
    int idx, k, seen, slot;
    idx = int'(a[5:0]);
    e_hit = 0; e_part = 0; e_cnt = 0; e_next = 0; e_words = '0;
    if (m_v[idx] && m_tag[idx] == a[31:6]) begin
      k = -1;
      for (int i = 0; i < int'(m_cnt[idx]); i++)
        if (k < 0 && m_dir[idx][i] != p[i]) k = i;
      if (k < 0) begin
        e_hit = 1; e_cnt = m_len[idx];
        if (m_last[idx] && m_cnt[idx] != 0)
          e_next = p[m_cnt[idx] - 1] ? m_tkn[idx] : m_fall[idx];
        else
          e_next = m_fall[idx];
      end else if (pe) begin
        seen = 0; slot = -1;
        for (int s = 0; s < 16; s++)
          if (m_mask[idx][s]) begin
            if (slot < 0 && seen == k) slot = s;
            seen++;
          end
        e_hit = 1; e_part = 1; e_cnt = 5'(slot + 1);
      end
    end
    for (int s = 0; s < 16; s++)
      if (s < int'(e_cnt)) e_words[s*32 +: 32] = m_words[idx][s*32 +: 32];
  endtask

  // one clock: drive at a falling edge, check at the next one
  task automatic cycle(input bit rv, input logic [31:0] ra, input logic [2:0] rp,
                       input bit rpe, input bit fv, input string tag);
    int fi;
    string t;
    req_vld = rv; req_addr = ra; req_pred = rp; req_partial_ok = rpe; fill_en = fv;
    e_vld = rv;
    expect_for(ra, rp, rpe);
    if (!rv) begin e_hit = 0; e_cnt = 0; e_next = 0; e_words = '0; e_part = 0; end
    if (fv) begin
      fi = int'(fill_addr[5:0]);
      m_v[fi] = 1; m_tag[fi] = fill_addr[31:6]; m_len[fi] = fill_len;
      m_cnt[fi] = fill_br_cnt; m_mask[fi] = fill_br_mask; m_dir[fi] = fill_br_dir;
      m_last[fi] = fill_last_br; m_fall[fi] = fill_fall_addr;
      m_tkn[fi] = fill_taken_addr; m_words[fi] = fill_words;
    end
    @(negedge clk);
    t = tag;
    if (t == "") t = !e_hit ? "R7/R3" : (e_part ? "R8" : "R4");
    chk(rsp_vld == e_vld, "R2", "rsp_vld", 64'(rsp_vld), 64'(e_vld));
    chk(rsp_hit == e_hit && rsp_partial == e_part, t, "hit/partial",
        64'({rsp_hit, rsp_partial}), 64'({e_hit, e_part}));
    chk(rsp_count == e_cnt, t, "count", 64'(rsp_count), 64'(e_cnt));
    chk(rsp_next_addr == e_next, (t == "R4") ? "R6" : t, "next_addr",
        64'(rsp_next_addr), 64'(e_next));
    for (int s = 0; s < 16; s++)
      if (rsp_words[s*32 +: 32] != e_words[s*32 +: 32])
        chk(1'b0, "R9/R11", $sformatf("word slot %0d", s),
            64'(rsp_words[s*32 +: 32]), 64'(e_words[s*32 +: 32]));
    fill_en = 0;
    req_vld = 0;
  endtask

  task automatic set_fill(input logic [31:0] a, input int len, input logic [15:0] mask,
                          input logic [2:0] dir, input logic [31:0] fl, input logic [31:0] tk,
                          input logic [31:0] wbase);
    int c;
    c = $countones(mask);
    fill_addr = a; fill_len = 5'(len); fill_br_mask = mask; fill_br_cnt = 2'(c);
    fill_br_dir = dir; fill_last_br = mask[len-1];
    fill_fall_addr = fl; fill_taken_addr = tk;
    for (int s = 0; s < 16; s++) fill_words[s*32 +: 32] = wbase + 32'(s);
  endtask

  task automatic rand_fill(input logic [31:0] a);
    int len, c;
    logic [15:0] mk;
    len = 1 + int'($urandom_range(15));
    mk = '0; c = 0;
    for (int s = 0; s < len; s++)
      if (c < 3 && $urandom_range(3) == 0) begin mk[s] = 1'b1; c++; end
    set_fill(a, len, mk, 3'($urandom), $urandom, $urandom, $urandom);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    logic [2:0]  p;
    int          idx;
    void'($urandom(32'd20240611));
    rst_n = 0; req_vld = 0; req_addr = 0; req_pred = 0; req_partial_ok = 0;
    fill_en = 0; set_fill(32'h0, 1, 16'h0, 3'h0, 32'h0, 32'h0, 32'h0);
    for (int i = 0; i < 64; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    // R1: quiet outputs in reset
    chk(rsp_vld == 0 && rsp_hit == 0 && rsp_count == 0, "R1", "reset outputs",
        64'({rsp_vld, rsp_hit, rsp_count}), 64'(0));
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(rsp_vld == 0, "R1", "idle after reset", 64'(rsp_vld), 64'(0));
    // R1: every line starts invalid
    cycle(1, 32'h0000_0005, 3'b000, 1, 0, "R1");
    cycle(1, 32'hFFFF_FFC0, 3'b111, 0, 0, "R1");

    // directed line at index 5: branches in slots 2 and 6, flags br0=0 br1=1
    set_fill({26'h123, 6'd5}, 7, 16'h0044, 3'b010, 32'h1000, 32'h2000, 32'hA000_0000);
    cycle(0, 0, 0, 0, 1, "R10");
    cycle(1, {26'h123, 6'd5}, 3'b110, 0, 0, "R5");
    chk(rsp_count == 7 && rsp_next_addr == 32'h2000, "R6", "taken successor",
        64'({rsp_count, rsp_next_addr}), 64'({5'd7, 32'h2000}));
    chk(rsp_words[6*32 +: 32] == 32'hA000_0006 && rsp_words[7*32 +: 32] == 0,
        "R11", "slot 6 word / slot 7 zero", 64'(rsp_words[6*32 +: 32]), 64'(32'hA000_0006));
    cycle(1, {26'h123, 6'd5}, 3'b000, 0, 0, "R7");
    cycle(1, {26'h123, 6'd5}, 3'b000, 1, 0, "R8");
    cycle(1, {26'h123, 6'd5}, 3'b011, 1, 0, "R8");
    chk(rsp_count == 3 && rsp_partial, "R8", "cut at first branch",
        64'(rsp_count), 64'(3));
    chk(rsp_words[3*32 +: 32] == 0 && rsp_words[2*32 +: 32] == 32'hA000_0002, "R9",
        "prefix gating", 64'(rsp_words[3*32 +: 32]), 64'(0));
    cycle(1, {26'h124, 6'd5}, 3'b010, 1, 0, "R3");

    // line at index 9 whose last slot is not a branch
    set_fill({26'h77, 6'd9}, 4, 16'h0001, 3'b001, 32'h3000, 32'h4000, 32'hB000_0000);
    cycle(0, 0, 0, 0, 1, "R10");
    cycle(1, {26'h77, 6'd9}, 3'b111, 0, 0, "R6");
    chk(rsp_next_addr == 32'h3000, "R6", "fall-through when no final branch",
        64'(rsp_next_addr), 64'(32'h3000));

    // line with no branches: predictions irrelevant
    set_fill({26'h5, 6'd12}, 16, 16'h0000, 3'b000, 32'h5000, 32'h6000, 32'hC000_0000);
    cycle(0, 0, 0, 0, 1, "R10");
    cycle(1, {26'h5, 6'd12}, 3'b101, 0, 0, "R5");

    // same-cycle fill and lookup of index 5: old line returned
    set_fill({26'h999, 6'd5}, 2, 16'h0002, 3'b001, 32'h7000, 32'h8000, 32'hD000_0000);
    cycle(1, {26'h123, 6'd5}, 3'b010, 0, 1, "R10");
    chk(rsp_hit && rsp_count == 7, "R10", "old contents on collision",
        64'({rsp_hit, rsp_count}), 64'({1'b1, 5'd7}));
    cycle(1, {26'h123, 6'd5}, 3'b010, 0, 0, "R3");
    cycle(1, {26'h999, 6'd5}, 3'b001, 0, 0, "R10");

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      idx = int'($urandom_range(63));
      a = {24'h0, 2'($urandom), 6'(idx)};
      if ($urandom_range(9) < 6 && m_v[idx]) p = m_dir[idx] ^ (3'($urandom) & ~3'((1 << m_cnt[idx]) - 1));
      else p = 3'($urandom);
      if ($urandom_range(3) == 0) rand_fill({24'h0, 2'($urandom), 6'($urandom_range(63))});
      cycle($urandom_range(4) != 0, a, p, $urandom_range(1) == 1,
            $urandom_range(3) == 0, "");
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule